// File: doc/BRIEF.md
# Multi-format audio serial transmitter

This block turns a stereo pair of parallel samples into one serial data line for an audio link. An external master supplies the bit clock and the frame clock. The block runs directly on the bit clock and changes its output only on falling edges, so that a receiver can capture each bit on the next rising edge. Three framings are supported. In left-aligned framing the word starts at the frame-clock change. In I2S framing the word starts one bit later. In right-aligned framing the word ends on the last bit slot before the next change. The word length is chosen from 16, 20, 24 or 32 bits.

Samples are right-aligned on 32-bit inputs. A write strobe captures a pair into a holding stage at any time. At the start of each left half-frame the held pair is moved to the active stage, and a one-bit-clock request pulse asks the source for the next pair. If the source sends nothing, the active pair is sent again. For right-aligned framing the block counts the bit slots of each half-frame and uses the length of the previous half to decide where the word begins.

Top module: `aud_ser_tx`

## Requirements
- R1: While `rst_n` is low, `sdata` and `pair_req` are low. After release, `sdata` stays low until a pair has been written through `smp_vld` and moved to the active stage.
- R2: With `fmt` = 0 or 3 (left-aligned), the falling edge that first sees a new `frame_clk` level drives the word's MSB. Each later falling edge drives the next lower bit.
- R3: With `fmt` = 2 (I2S), the MSB is driven one falling edge after the edge that sees the level change. When a half-frame is exactly as long as the word, its LSB appears in slot 0 of the following half-frame.
- R4: With `fmt` = 1 (right-aligned), the word's LSB is driven on the last slot before the next `frame_clk` change. The start slot is the previous half-frame's slot count minus the word length.
- R5: In left- and right-aligned framing, a high `frame_clk` carries the left sample. In I2S framing, a low `frame_clk` carries the left sample. Bits are sent MSB first.
- R6: `wsel` codes 0, 1, 2 and 3 select 16, 20, 24 and 32 bits. Only the low bits of `smp_l`/`smp_r` are used, and higher bits have no effect on `sdata`.
- R7: Every slot that carries no word bit is driven low.
- R8: A falling edge with `smp_vld` high captures `smp_l`/`smp_r` into the holding stage. On the edge that opens a left half-frame, the held pair becomes active and `pair_req` goes high for exactly that one bit clock.
- R9: If no pair is written during a frame, the next frame sends the previous active pair unchanged, even when the data inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock; all state updates on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt | input | 2 | Framing: 0/3 left-aligned, 1 right-aligned, 2 I2S |
| wsel | input | 2 | Word length: 0=16, 1=20, 2=24, 3=32 bits |
| frame_clk | input | 1 | Left/right frame clock from the master |
| smp_l | input | DW | Left sample, right-aligned |
| smp_r | input | DW | Right sample, right-aligned |
| smp_vld | input | 1 | Write strobe for the sample pair |
| sdata | output | 1 | Serial data, changes on falling bit_clk edges |
| pair_req | output | 1 | One-bit-clock request for the next pair |

## Verification
The bench uses the default parameters: DW = 32 and an 8-bit slot counter. With these values all four word lengths can be tested, including the 32-bit word that exactly fills a 32-slot half-frame, where the I2S LSB spills into the next half. The counter allows half-frames of up to 255 slots. The stimulus uses 20, 24 and 32 slots, which gives right-aligned offsets of 4 and 16 and idle tails after the left-aligned and I2S words.

// File: rtl/aud_ser_tx.sv
module aud_ser_tx #(
  parameter int DW = 32,
  parameter int CW = 8
) (
  input  logic          bit_clk,
  input  logic          rst_n,
  input  logic [1:0]    fmt,
  input  logic [1:0]    wsel,
  input  logic          frame_clk,
  input  logic [DW-1:0] smp_l,
  input  logic [DW-1:0] smp_r,
  input  logic          smp_vld,
  output logic          sdata,
  output logic          pair_req
);
  localparam int WB = $clog2(DW + 1);

  logic          fc_q;
  logic [CW-1:0] cnt, hlen, slot, cnt_inc, rj_start, start_slot;
  logic [WB-1:0] wbits;
  logic [DW-1:0] hold_l, hold_r, act_l, act_r, shreg, word, aligned;

  wire is_rj     = (fmt == 2'd1);
  wire is_i2s    = (fmt == 2'd2);
  wire fc_edge   = (frame_clk != fc_q);
  wire left_now  = is_i2s ? ~frame_clk : frame_clk;
  wire left_edge = fc_edge & left_now;

  always_comb begin
    case (wsel)
      2'd0:    wbits = WB'(16);
      2'd1:    wbits = WB'(20);
      2'd2:    wbits = WB'(24);
      default: wbits = WB'(32);
    endcase
  end

  assign cnt_inc    = (&cnt) ? cnt : cnt + 1'b1;
  assign slot       = fc_edge ? '0 : cnt_inc;
  assign rj_start   = (hlen > CW'(wbits)) ? hlen - CW'(wbits) : '0;
  assign start_slot = is_rj ? rj_start : (is_i2s ? CW'(1) : '0);
  assign word       = left_now ? (left_edge ? hold_l : act_l) : act_r;
  assign aligned    = word << (WB'(DW) - wbits);

  always_ff @(negedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      fc_q     <= 1'b0;
      cnt      <= '0;
      hlen     <= '0;
      hold_l   <= '0;
      hold_r   <= '0;
      act_l    <= '0;
      act_r    <= '0;
      shreg    <= '0;
      sdata    <= 1'b0;
      pair_req <= 1'b0;
    end else begin
      fc_q     <= frame_clk;
      cnt      <= slot;
      pair_req <= left_edge;
      if (fc_edge) hlen <= cnt_inc;
      if (smp_vld) begin
        hold_l <= smp_l;
        hold_r <= smp_r;
      end
      if (left_edge) begin
        act_l <= hold_l;
        act_r <= hold_r;
      end
      if (slot == start_slot) begin
        sdata <= aligned[DW-1];
        shreg <= aligned << 1;
      end else begin
        sdata <= shreg[DW-1];
        shreg <= shreg << 1;
      end
    end
  end
endmodule

// File: rtl/aud_ser_tx_chk.sv
module aud_ser_tx_chk #(
  parameter int CW = 8
) (
  input logic       bit_clk,
  input logic       rst_n,
  input logic [1:0] fmt,
  input logic [1:0] wsel,
  input logic       frame_clk,
  input logic       sdata,
  input logic       pair_req
);
  logic          fp, stab;
  logic [CW-1:0] c;
  logic [3:0]    cref;

  function automatic int wlen_of(input logic [1:0] code);
    case (code)
      2'd0:    return 16;
      2'd1:    return 20;
      2'd2:    return 24;
      default: return 32;
    endcase
  endfunction

  always_ff @(negedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      fp   <= 1'b0;
      c    <= '0;
      stab <= 1'b0;
      cref <= '0;
    end else begin
      fp <= frame_clk;
      if (frame_clk != fp) begin
        c    <= '0;
        stab <= 1'b1;
        cref <= {fmt, wsel};
      end else begin
        if (c != '1) c <= c + 1'b1;
        if ({fmt, wsel} != cref) stab <= 1'b0;
      end
    end
  end

  always @(negedge bit_clk) begin
    if (!rst_n) assert_reset_quiet_R1: assert (!sdata && !pair_req);
  end

  assert_req_single_R8: assert property (@(negedge bit_clk) disable iff (!rst_n)
    pair_req |=> !pair_req);

  assert_req_on_edge_R8: assert property (@(negedge bit_clk) disable iff (!rst_n)
    pair_req |-> $past(frame_clk != fp));

  assert_lj_tail_low_R7: assert property (@(negedge bit_clk) disable iff (!rst_n)
    (stab && cref[3:2] != 2'd1 && cref[3:2] != 2'd2 && int'(c) >= wlen_of(cref[1:0]))
      |-> !sdata);
endmodule

bind aud_ser_tx aud_ser_tx_chk #(.CW(CW)) u_chk (
  .bit_clk(bit_clk), .rst_n(rst_n), .fmt(fmt), .wsel(wsel),
  .frame_clk(frame_clk), .sdata(sdata), .pair_req(pair_req)
);

// File: tb/sim_aud_ser_tx.sv
module sim_aud_ser_tx;
  logic        clk = 0, rst_n = 0, fc = 0, vld = 0;
  logic [1:0]  fmt = 0, wsel = 0;
  logic [31:0] sl = 0, sr = 0;
  logic        sd, req;
  int          checks = 0, fails = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  aud_ser_tx u0 (
    .bit_clk(clk), .rst_n(rst_n), .fmt(fmt), .wsel(wsel), .frame_clk(fc),
    .smp_l(sl), .smp_r(sr), .smp_vld(vld), .sdata(sd), .pair_req(req)
  );

  // {fmt, wsel, half-frame slots, load, left, right}
  localparam logic [76:0] VEC [7] = '{
    {2'd0, 2'd2, 8'd32, 1'b1, 32'hA5C3_9E71, 32'h1234_5678},
    {2'd1, 2'd0, 8'd32, 1'b1, 32'hFFFF_8001, 32'h0000_7FFE},
    {2'd2, 2'd3, 8'd32, 1'b1, 32'hDEAD_BEEF, 32'h8000_0001},
    {2'd2, 2'd0, 8'd24, 1'b1, 32'h0BAD_F00D, 32'h7135_0C2A},
    {2'd1, 2'd1, 8'd24, 1'b1, 32'h00F0_F0F1, 32'hABCD_E123},
    {2'd0, 2'd0, 8'd20, 1'b0, 32'h5555_AAAA, 32'hC3C3_3C3C},
    {2'd3, 2'd3, 8'd32, 1'b1, 32'h8000_0000, 32'hFFFF_FFFF}
  };

  task automatic chk(input string rq, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", rq, act, exp, $time);
    end
  endtask

  function automatic int wbits(input logic [1:0] code);
    case (code)
      2'd0: return 16;
      2'd1: return 20;
      2'd2: return 24;
      default: return 32;
    endcase
  endfunction

  function automatic logic exp_bit(input int f, input int w, input int len, input int s,
                                   input logic [31:0] cur, input logic [31:0] prv,
                                   output bit isd);
    int k;
    isd = 0;
    if (f == 1) begin
      k = s - (len - w);
      if (k >= 0) begin isd = 1; return cur[w-1-k]; end
    end else if (f == 2) begin
      if (s == 0) begin
        if (len == w) begin isd = 1; return prv[0]; end
      end else if (s - 1 < w) begin
        isd = 1; return cur[w-s];
      end
    end else if (s < w) begin
      isd = 1; return cur[w-1-s];
    end
    return 1'b0;
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] cl, cr;
    cl = 0; cr = 0;
    repeat (3) begin
      @(posedge clk);
      fc = ~fc;
      chk("R1 reset sdata", sd, 1'b0);
      chk("R1 reset pair_req", req, 1'b0);
    end
    @(posedge clk);
    rst_n = 1;
    fc = 0;

    for (int v = 0; v < 7; v++) begin
      logic [76:0] e;
      int f, w, len;
      logic ld, lv;
      logic [31:0] nl, nr;
      e   = VEC[v];
      f   = int'(e[76:75]);
      w   = wbits(e[74:73]);
      len = int'(e[72:65]);
      ld  = e[64];
      nl  = e[63:32];
      nr  = e[31:0];
      if (ld) begin cl = nl; cr = nr; end
      fmt  = e[76:75];
      wsel = e[74:73];
      lv   = (f == 2) ? 1'b0 : 1'b1;
      for (int fr = 0; fr < 4; fr++) begin
        for (int h = 0; h < 2; h++) begin
          for (int s = 0; s < len; s++) begin
            logic ebit;
            bit isd;
            string tag;
            fc  = (h == 0) ? lv : ~lv;
            sl  = nl;
            sr  = nr;
            vld = ld && fr == 0 && h == 1 && s == 0;
            @(posedge clk);
            if (fr >= 2) begin
              ebit = exp_bit(f, w, len, s, h ? cr : cl, h ? cl : cr, isd);
              if (isd) tag = (f == 1) ? "R4 R5 R6" : (f == 2) ? "R3 R5 R6" : "R2 R5 R6";
              else     tag = "R7";
              if (!ld) tag = {tag, " R9"};
              chk(tag, sd, ebit);
              chk("R8 pair_req", req, h == 0 && s == 0);
            end
          end
        end
      end
    end

    fc = ~fc;
    @(posedge clk);
    rst_n = 0;
    #1;
    chk("R1 async reset sdata", sd, 1'b0);
    chk("R1 async reset pair_req", req, 1'b0);
    repeat (2) @(posedge clk);
    chk("R1 held reset sdata", sd, 1'b0);
    rst_n = 1;
    fmt = 2'd0;
    wsel = 2'd0;
    sl = 32'hFFFF_FFFF;
    sr = 32'hFFFF_FFFF;
    for (int fr = 0; fr < 3; fr++) begin
      for (int h = 0; h < 2; h++) begin
        for (int s = 0; s < 16; s++) begin
          fc = (h == 0);
          @(posedge clk);
          chk("R1 empty after reset", sd, 1'b0);
          chk("R8 pair_req after reset", req, h == 0 && s == 0);
        end
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule